// File: doc/BRIEF.md
# Unified Serial Frame Parser

This block sits behind a byte-wide receiver (UART or SPI shift logic) and turns a stream of received bytes, each marked by a valid strobe, into decoded messages. A message opens with the start byte 0xFE. The start byte is followed by a two-byte payload length, a byte that packs a message type and a subsystem ID, and a command byte. Then come the payload bytes and a final XOR check byte. The parser presents the header fields as soon as the command byte has arrived. It streams the payload out byte by byte with first and last markers, and it reports at the end whether the check byte matched.

Between frames the parser looks for the start byte. Any other byte it sees while looking is dropped and counted in a saturating counter. A 0xFE that arrives inside a frame is ordinary data. Routing by subsystem, frame storage and the serial physical layer belong to the blocks around this one.

Top module: `sfp_frame_parser`

## Requirements
- R1: While hunting, an accepted byte equal to 0xFE starts a frame. Any other accepted byte is discarded and increments `drop_count` by one, and the increment shows one cycle after that byte.
- R2: The two bytes after the start byte form the length, low byte first. `hdr_len` equals `{second byte, first byte}`.
- R3: The next byte carries the type and subsystem. `hdr_type` takes bits 7:5 of it and `hdr_subsys` takes bits 4:0. The byte after that is `hdr_cmd`. `hdr_valid` pulses for one cycle, one cycle after the command byte is accepted. All header outputs keep their values until the next header.
- R4: Exactly `hdr_len` payload bytes follow the command byte. Each one appears on `pl_data` with `pl_valid` high for one cycle, one cycle after it is accepted. `pl_first` marks the first of these bytes and `pl_last` marks the final one.
- R5: A length of zero produces no `pl_valid` pulse. The byte after the command byte is then taken as the check byte.
- R6: The check value is the XOR of every byte from the low length byte through the last payload byte, with the start byte excluded. If the check byte equals it, `frame_good` pulses for one cycle, one cycle after the check byte.
- R7: If the check byte differs, `frame_err` pulses instead of `frame_good`. In both cases the parser then returns to hunting.
- R8: `type_bad` is high together with the header when the type code is not 1 (synchronous request), 2 (asynchronous request or indication) or 3 (synchronous response). The header, payload and check are still handled normally.
- R9: `drop_count` saturates at 2^CNT_W-1 and stays there.
- R10: A cycle with `in_valid` low changes no parser state and produces no pulse.
- R11: After reset, all pulse outputs are low, the header fields and `drop_count` are zero, and the parser is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Received byte |
| in_valid | input | 1 | `in_byte` is valid this cycle |
| hdr_valid | output | 1 | One-cycle pulse: header fields updated |
| hdr_len | output | 16 | Payload length |
| hdr_type | output | 3 | Message type code |
| hdr_subsys | output | 5 | Subsystem ID |
| hdr_cmd | output | 8 | Command ID |
| type_bad | output | 1 | Type code outside 1..3 |
| pl_data | output | 8 | Payload byte |
| pl_valid | output | 1 | `pl_data` valid |
| pl_first | output | 1 | First payload byte |
| pl_last | output | 1 | Final payload byte |
| frame_good | output | 1 | Check byte matched |
| frame_err | output | 1 | Check byte mismatched |
| drop_count | output | CNT_W | Saturating count of bytes discarded while hunting |

## Verification
On every cycle the assertions check several properties:
- `frame_good` and `frame_err` are never high together, and the parser is hunting after either one.
- The payload markers only appear together with `pl_valid`.
- A zero-length header is never followed by a payload pulse.
- `type_bad` only changes together with a header.
- The discard counter never decreases and steps by exactly one on a discard.

The remaining properties are only shown by the bench's scenarios against its reference model: the correct little-endian length, the exact payload count and markers, the XOR value itself, the behaviour of 0xFE inside a payload, idle gaps, and saturation of the counter.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    localparam int BYTE_W = 8;
    localparam int LEN_W  = 2 * BYTE_W;
    localparam int TYPE_W = 3;
    localparam int SUB_W  = BYTE_W - TYPE_W;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LEN_LO,
        ST_LEN_HI,
        ST_TYPE,
        ST_CMD,
        ST_BODY,
        ST_CHECK
    } parse_st_e;

    typedef struct packed {
        parse_st_e          st;
        logic [BYTE_W-1:0]  len_lo;
        logic [LEN_W-1:0]   len;
        logic [BYTE_W-1:0]  tbyte;
        logic [LEN_W-1:0]   rem;
        logic               first;
        logic [LEN_W-1:0]   o_len;
        logic [TYPE_W-1:0]  o_type;
        logic [SUB_W-1:0]   o_sub;
        logic [BYTE_W-1:0]  o_cmd;
        logic               o_bad;
        logic               o_hdr_v;
        logic [BYTE_W-1:0]  o_pl_data;
        logic               o_pl_v;
        logic               o_pl_first;
        logic               o_pl_last;
        logic               o_good;
        logic               o_err;
    } parse_regs_t;

    function automatic logic known_type(input logic [TYPE_W-1:0] t);
        return (t == TYPE_W'(1)) || (t == TYPE_W'(2)) || (t == TYPE_W'(3));
    endfunction

endpackage

// File: rtl/sfp_xor_acc.sv
module sfp_xor_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] acc
);
    logic [W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr)     acc_d = '0;
        else if (en) acc_d = acc_q ^ din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));
endmodule

// File: rtl/sfp_drop_ctr.sv
module sfp_drop_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R9
    no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q >= $past(cnt_q)));

    // R1
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/sfp_frame_parser.sv
module sfp_frame_parser
    import sfp_pkg::*;
#(
    parameter logic [7:0] SOF_BYTE = 8'hFE,
    parameter int         CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_byte,
    input  logic             in_valid,
    output logic             hdr_valid,
    output logic [15:0]      hdr_len,
    output logic [2:0]       hdr_type,
    output logic [4:0]       hdr_subsys,
    output logic [7:0]       hdr_cmd,
    output logic             type_bad,
    output logic [7:0]       pl_data,
    output logic             pl_valid,
    output logic             pl_first,
    output logic             pl_last,
    output logic             frame_good,
    output logic             frame_err,
    output logic [CNT_W-1:0] drop_count
);
    parse_regs_t       r_d, r_q;
    logic              drop_inc;
    logic              acc_clr;
    logic              acc_en;
    logic [BYTE_W-1:0] acc_val;

    sfp_xor_acc #(.W(BYTE_W)) xor_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (acc_en),
        .din   (in_byte),
        .acc   (acc_val)
    );

    sfp_drop_ctr #(.W(CNT_W)) drop_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (drop_inc),
        .cnt   (drop_count)
    );

    always_comb begin
        r_d            = r_q;
        r_d.o_hdr_v    = 1'b0;
        r_d.o_pl_v     = 1'b0;
        r_d.o_pl_first = 1'b0;
        r_d.o_pl_last  = 1'b0;
        r_d.o_good     = 1'b0;
        r_d.o_err      = 1'b0;
        drop_inc       = 1'b0;
        acc_clr        = 1'b0;
        acc_en         = 1'b0;
        if (in_valid) begin
            unique case (r_q.st)
                ST_HUNT: begin
                    if (in_byte == SOF_BYTE) begin
                        r_d.st  = ST_LEN_LO;
                        acc_clr = 1'b1;
                    end else begin
                        drop_inc = 1'b1;
                    end
                end
                ST_LEN_LO: begin
                    acc_en     = 1'b1;
                    r_d.len_lo = in_byte;
                    r_d.st     = ST_LEN_HI;
                end
                ST_LEN_HI: begin
                    acc_en  = 1'b1;
                    r_d.len = {in_byte, r_q.len_lo};
                    r_d.st  = ST_TYPE;
                end
                ST_TYPE: begin
                    acc_en    = 1'b1;
                    r_d.tbyte = in_byte;
                    r_d.st    = ST_CMD;
                end
                ST_CMD: begin
                    acc_en      = 1'b1;
                    r_d.o_hdr_v = 1'b1;
                    r_d.o_len   = r_q.len;
                    r_d.o_type  = r_q.tbyte[BYTE_W-1 -: TYPE_W];
                    r_d.o_sub   = r_q.tbyte[SUB_W-1:0];
                    r_d.o_cmd   = in_byte;
                    r_d.o_bad   = !known_type(r_q.tbyte[BYTE_W-1 -: TYPE_W]);
                    r_d.rem     = r_q.len;
                    r_d.first   = 1'b1;
                    r_d.st      = (r_q.len == '0) ? ST_CHECK : ST_BODY;
                end
                ST_BODY: begin
                    acc_en         = 1'b1;
                    r_d.o_pl_v     = 1'b1;
                    r_d.o_pl_data  = in_byte;
                    r_d.o_pl_first = r_q.first;
                    r_d.first      = 1'b0;
                    r_d.o_pl_last  = (r_q.rem == LEN_W'(1));
                    r_d.rem        = r_q.rem - 1'b1;
                    if (r_q.rem == LEN_W'(1)) r_d.st = ST_CHECK;
                end
                ST_CHECK: begin
                    if (in_byte == acc_val) r_d.o_good = 1'b1;
                    else                    r_d.o_err  = 1'b1;
                    r_d.st = ST_HUNT;
                end
                default: r_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign hdr_valid  = r_q.o_hdr_v;
    assign hdr_len    = r_q.o_len;
    assign hdr_type   = r_q.o_type;
    assign hdr_subsys = r_q.o_sub;
    assign hdr_cmd    = r_q.o_cmd;
    assign type_bad   = r_q.o_bad;
    assign pl_data    = r_q.o_pl_data;
    assign pl_valid   = r_q.o_pl_v;
    assign pl_first   = r_q.o_pl_first;
    assign pl_last    = r_q.o_pl_last;
    assign frame_good = r_q.o_good;
    assign frame_err  = r_q.o_err;

    // R7
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_good, frame_err}));

    // R7
    verdict_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_good || frame_err) |-> (r_q.st == ST_HUNT));

    // R4
    marker_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_first || pl_last) |-> pl_valid);

    // R5
    empty_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_len == '0) |=> !pl_valid);

    // R8
    bad_type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |-> $stable(type_bad));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(pl_valid || hdr_valid || frame_good || frame_err));
endmodule

// File: tb/sfp_frame_parser_tb_top.sv
module sfp_frame_parser_tb_top;
    localparam int CNT_W   = 8;
    localparam int DROP_MX = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       in_byte = 8'h00;
    logic             in_valid = 1'b0;
    logic             hdr_valid;
    logic [15:0]      hdr_len;
    logic [2:0]       hdr_type;
    logic [4:0]       hdr_subsys;
    logic [7:0]       hdr_cmd;
    logic             type_bad;
    logic [7:0]       pl_data;
    logic             pl_valid, pl_first, pl_last;
    logic             frame_good, frame_err;
    logic [CNT_W-1:0] drop_count;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sfp_frame_parser #(.SOF_BYTE(8'hFE), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .hdr_valid(hdr_valid), .hdr_len(hdr_len), .hdr_type(hdr_type),
        .hdr_subsys(hdr_subsys), .hdr_cmd(hdr_cmd), .type_bad(type_bad),
        .pl_data(pl_data), .pl_valid(pl_valid), .pl_first(pl_first),
        .pl_last(pl_last), .frame_good(frame_good), .frame_err(frame_err),
        .drop_count(drop_count)
    );

    // reference model state
    int   m_phase = 0;
    int   m_len = 0, m_cnt = 0, m_drop = 0;
    logic [7:0] m_lo = 0, m_xor = 0, m_typ = 0;
    logic e_hv, e_pv, e_pf, e_pl, e_good, e_err, e_bad;
    logic [15:0] e_len;
    logic [2:0]  e_type;
    logic [4:0]  e_sub;
    logic [7:0]  e_cmd, e_pd;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model(input logic v, input logic [7:0] b);
        e_hv = 0; e_pv = 0; e_pf = 0; e_pl = 0; e_good = 0; e_err = 0;
        if (v) begin
            case (m_phase)
                0: if (b == 8'hFE) begin m_phase = 1; m_xor = 0; end
                   else if (m_drop < DROP_MX) m_drop++;
                1: begin m_xor ^= b; m_lo = b; m_phase = 2; end
                2: begin m_xor ^= b; m_len = {b, m_lo}; m_phase = 3; end
                3: begin m_xor ^= b; m_typ = b; m_phase = 4; end
                4: begin
                    m_xor ^= b; e_hv = 1; e_len = 16'(m_len);
                    e_type = m_typ[7:5]; e_sub = m_typ[4:0]; e_cmd = b;
                    e_bad = !(e_type >= 1 && e_type <= 3);
                    m_cnt = 0; m_phase = (m_len == 0) ? 6 : 5;
                end
                5: begin
                    m_xor ^= b; e_pv = 1; e_pd = b;
                    e_pf = (m_cnt == 0); e_pl = (m_cnt == m_len - 1);
                    m_cnt++;
                    if (m_cnt == m_len) m_phase = 6;
                end
                default: begin
                    if (b == m_xor) e_good = 1; else e_err = 1;
                    m_phase = 0;
                end
            endcase
        end
    endtask

    task automatic compare();
        chk("R3 hdr_valid (R10)", 32'(hdr_valid), 32'(e_hv));
        chk("R2 hdr_len", 32'(hdr_len), 32'(e_len));
        chk("R3 hdr_type", 32'(hdr_type), 32'(e_type));
        chk("R3 hdr_subsys", 32'(hdr_subsys), 32'(e_sub));
        chk("R3 hdr_cmd", 32'(hdr_cmd), 32'(e_cmd));
        chk("R8 type_bad", 32'(type_bad), 32'(e_bad));
        chk("R4 R5 pl_valid (R10)", 32'(pl_valid), 32'(e_pv));
        chk("R4 pl_first", 32'(pl_first), 32'(e_pf));
        chk("R4 pl_last", 32'(pl_last), 32'(e_pl));
        if (e_pv) chk("R4 pl_data", 32'(pl_data), 32'(e_pd));
        chk("R6 frame_good", 32'(frame_good), 32'(e_good));
        chk("R7 frame_err", 32'(frame_err), 32'(e_err));
        chk("R1 R9 drop_count", 32'(drop_count), 32'(m_drop));
    endtask

    // inputs driven after a falling edge, outputs sampled 2 ns after the rising edge
    task automatic step(input logic v, input logic [7:0] b);
        in_valid = v; in_byte = b;
        model(v, b);
        @(posedge clk); #2;
        compare();
        @(negedge clk);
    endtask

    task automatic send_frame(input int len, input logic [7:0] tb, input logic [7:0] cmd,
                              input logic corrupt, input int gap);
        logic [7:0] q[$];
        logic [7:0] x;
        q.push_back(8'hFE);
        q.push_back(len[7:0]);
        q.push_back(len[15:8]);
        q.push_back(tb);
        q.push_back(cmd);
        for (int i = 0; i < len; i++) q.push_back((i % 5 == 2) ? 8'hFE : 8'((i * 7 + len) & 255));
        x = 0;
        for (int i = 1; i < q.size(); i++) x ^= q[i];
        q.push_back(corrupt ? (x ^ 8'h5A) : x);
        foreach (q[k]) begin
            step(1'b1, q[k]);
            for (int g = 0; g < gap; g++) step(1'b0, 8'hFE);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        e_len = 0; e_type = 0; e_sub = 0; e_cmd = 0; e_bad = 0; e_pd = 0;
        e_hv = 0; e_pv = 0; e_pf = 0; e_pl = 0; e_good = 0; e_err = 0;
        repeat (3) @(negedge clk);
        #0;
        // R11 reset state
        chk("R11 reset pulses", 32'({hdr_valid, pl_valid, frame_good, frame_err}), 32'h0);
        chk("R11 reset fields", 32'({hdr_len, hdr_cmd}), 32'h0);
        chk("R11 reset drop_count", 32'(drop_count), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 junk before a frame
        step(1'b1, 8'h00); step(1'b1, 8'hFF); step(1'b1, 8'h12);
        // R2 R3 R4 R6 sync request, short payload
        send_frame(3, 8'h25, 8'h81, 1'b0, 0);
        // R5 zero length async
        send_frame(0, 8'h41, 8'h10, 1'b0, 0);
        // R7 corrupted check byte
        send_frame(4, 8'h6F, 8'h33, 1'b1, 0);
        // R8 type codes 0 and 7
        send_frame(2, 8'h03, 8'h01, 1'b0, 0);
        send_frame(0, 8'hE9, 8'h02, 1'b1, 0);
        // R10 idle gaps inside a frame
        send_frame(5, 8'h62, 8'hA5, 1'b0, 2);
        // R2 length with non-zero high byte (260)
        send_frame(260, 8'h7F, 8'hC3, 1'b0, 0);
        // R9 saturation of drop counter
        for (int i = 0; i < 300; i++) step(1'b1, 8'(i % 200));
        // R1 frame still found after saturation
        send_frame(1, 8'h21, 8'h44, 1'b0, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule